// File: doc/BRIEF.md
# Audio Decoder Control Register Bank with Run Handshake

This block holds the byte-wide control registers of an audio decoder core. Two synchronous ports reach it: one from the internal DSP and one from an external host. Each port has an address, a write enable, write data and combinational read data. The registers are:

- the run state;
- a flag that bypasses CRC checking;
- a mute flag;
- a frame-skip count;
- a pause flag;
- the data-path mode selector.

Each register value is also driven onto a dedicated output, so the decoder datapath can use it.

The run register carries a three-step handshake. After a software reset it holds 0. When the DSP finishes booting, it writes 2, which opens a configuration window for the host. The host closes that window by writing 1, which starts decoding and raises the decode-enable output. During the window the host may set the mode, the CRC bypass and the skip count. Outside the window the host may change only mute and pause. A synchronous software reset input clears every register and takes precedence over any write in the same cycle.

Top module: `dcr_ctrl`

## Requirements
- R1: After the asynchronous reset, and after a software reset, every register reads 0x00 and `decode_en_o` and `sine_test_o` are low.
- R2: A DSP write of 2 to the run register (address 0x56) while it holds 0 sets it to 2, opening the configuration window. Any other DSP write to the run register is ignored.
- R3: A host write of 1 to the run register while it holds 2 sets it to 1 and raises `decode_en_o` on the next cycle. A host write of 1 in any other state is ignored.
- R4: `decode_en_o` is high only while the run register holds 1. Once set to 1, the run register keeps that value until a software reset, and `decode_en_o` drops in the cycle after that reset.
- R5: Host writes to the mode register (0x51), the CRC-bypass register (0x52) and the skip register (0x57) take effect only while the run register holds 2. In any other state they are ignored.
- R6: A write of mode code 2 or 5 (reserved), or of a code above 10, is ignored and the mode register keeps its previous value. Mode code 10 drives `sine_test_o` high.
- R7: A software reset in the same cycle as any write leaves the registers at their reset values.
- R8: Both read ports return the register at the given address, zero-extended: mode at 0x51, CRC bypass at 0x52 (bit 0), mute at 0x53 (bit 0), run at 0x56, skip at 0x57 and pause at 0x58 (bit 0). Any other address reads 0x00.
- R9: Host writes to mute (0x53) and pause (0x58) take effect in every run state. DSP writes to mode, CRC bypass, mute, skip and pause take effect in every run state.
- R10: When both ports write the same configuration register in one cycle, the DSP value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_rst_i | input | 1 | Synchronous software reset, highest priority |
| dsp_we_i | input | 1 | DSP port write enable |
| dsp_addr_i | input | AW | DSP port address |
| dsp_wdata_i | input | DW | DSP port write data |
| dsp_rdata_o | output | DW | DSP port read data |
| host_we_i | input | 1 | Host port write enable |
| host_addr_i | input | AW | Host port address |
| host_wdata_i | input | DW | Host port write data |
| host_rdata_o | output | DW | Host port read data |
| decode_en_o | output | 1 | High while decoding is commanded |
| mode_o | output | MW | Data-path mode code |
| skip_o | output | DW | Frame-skip count |
| crc_ignore_o | output | 1 | CRC checking bypassed |
| mute_o | output | 1 | Decoder muted |
| pause_o | output | 1 | Decoder paused |
| sine_test_o | output | 1 | Sine test mode selected |

## Verification
A write, or a software reset, is sampled at one rising edge, and its effect is visible from that edge onward. The run state, every register output, `decode_en_o` and `sine_test_o` therefore change exactly one cycle after the stimulus is driven. Read data is combinational on the stored state, so it reflects a change at the same edge. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It then points the read address at the target register and samples 1 ns later, after exactly one rising edge has passed.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  typedef enum logic [1:0] {
    RUN_IDLE = 2'd0,
    RUN_GO   = 2'd1,
    RUN_CFG  = 2'd2
  } run_state_e;

  localparam logic [7:0] ADDR_MODE  = 8'h51;
  localparam logic [7:0] ADDR_CRC   = 8'h52;
  localparam logic [7:0] ADDR_MUTE  = 8'h53;
  localparam logic [7:0] ADDR_RUN   = 8'h56;
  localparam logic [7:0] ADDR_SKIP  = 8'h57;
  localparam logic [7:0] ADDR_PAUSE = 8'h58;

  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_CRC   = 0;
  localparam int unsigned FLAG_MUTE  = 1;
  localparam int unsigned FLAG_PAUSE = 2;

  localparam logic [7:0] MODE_SINE  = 8'd10;
  localparam logic [7:0] MODE_RSV_A = 8'd2;
  localparam logic [7:0] MODE_RSV_B = 8'd5;

  localparam logic [7:0] RUN_CMD_BOOTED = 8'd2;
  localparam logic [7:0] RUN_CMD_START  = 8'd1;

  function automatic logic mode_valid(input logic [7:0] code);
    return (code <= MODE_SINE) && (code != MODE_RSV_A) && (code != MODE_RSV_B);
  endfunction

endpackage

// File: rtl/dcr_run_fsm.sv
module dcr_run_fsm
  import dcr_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_rst_i,
  input  logic          dsp_we_i,
  input  logic [AW-1:0] dsp_addr_i,
  input  logic [DW-1:0] dsp_wdata_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output run_state_e    run_o
);

  run_state_e run_q, run_d;

  logic dsp_boot_wr, host_start_wr;
  assign dsp_boot_wr   = dsp_we_i && (dsp_addr_i == AW'(ADDR_RUN))
                         && (dsp_wdata_i == DW'(RUN_CMD_BOOTED));
  assign host_start_wr = host_we_i && (host_addr_i == AW'(ADDR_RUN))
                         && (host_wdata_i == DW'(RUN_CMD_START));

  always_comb begin
    run_d = run_q;
    unique case (run_q)
      RUN_IDLE: if (dsp_boot_wr)   run_d = RUN_CFG;
      RUN_CFG:  if (host_start_wr) run_d = RUN_GO;
      RUN_GO:   run_d = RUN_GO;
      default:  run_d = RUN_IDLE;
    endcase
    if (sw_rst_i) run_d = RUN_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= RUN_IDLE;
    else         run_q <= run_d;
  end

  assign run_o = run_q;

  // R7
  sw_rst_clears_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> (run_q == RUN_IDLE));

  // R4
  go_is_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == RUN_GO && !sw_rst_i) |=> (run_q == RUN_GO));

  // R3
  go_needs_host_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q != RUN_GO) ##1 (run_q == RUN_GO) |->
      $past(host_we_i && host_addr_i == AW'(ADDR_RUN) && host_wdata_i == DW'(RUN_CMD_START)));

  // R2
  boot_opens_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == RUN_IDLE && dsp_boot_wr && !sw_rst_i) |=> (run_q == RUN_CFG));

endmodule

// File: rtl/dcr_cfg_regs.sv
module dcr_cfg_regs
  import dcr_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned MW = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sw_rst_i,
  input  logic                 run_cfg_i,
  input  logic                 dsp_we_i,
  input  logic [AW-1:0]        dsp_addr_i,
  input  logic [DW-1:0]        dsp_wdata_i,
  input  logic                 host_we_i,
  input  logic [AW-1:0]        host_addr_i,
  input  logic [DW-1:0]        host_wdata_i,
  output logic [MW-1:0]        mode_o,
  output logic [DW-1:0]        skip_o,
  output logic [NUM_FLAGS-1:0] flags_o
);

  localparam logic [7:0] FLAG_ADDR  [NUM_FLAGS] = '{ADDR_CRC, ADDR_MUTE, ADDR_PAUSE};
  localparam bit         FLAG_GATED [NUM_FLAGS] = '{1'b1, 1'b0, 1'b0};

  // Flags: host access gated by the configuration window where the map says so
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    logic dsp_hit, host_hit, flag_q;
    assign dsp_hit  = dsp_we_i && (dsp_addr_i == AW'(FLAG_ADDR[g]));
    assign host_hit = host_we_i && (host_addr_i == AW'(FLAG_ADDR[g]))
                      && (run_cfg_i || !FLAG_GATED[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (sw_rst_i) flag_q <= 1'b0;
      else if (dsp_hit)  flag_q <= dsp_wdata_i[0];
      else if (host_hit) flag_q <= host_wdata_i[0];
    end
    assign flags_o[g] = flag_q;
  end

  // Skip count
  logic [DW-1:0] skip_q;
  logic skip_dsp_hit, skip_host_hit;
  assign skip_dsp_hit  = dsp_we_i && (dsp_addr_i == AW'(ADDR_SKIP));
  assign skip_host_hit = host_we_i && (host_addr_i == AW'(ADDR_SKIP)) && run_cfg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            skip_q <= '0;
    else if (sw_rst_i)      skip_q <= '0;
    else if (skip_dsp_hit)  skip_q <= dsp_wdata_i;
    else if (skip_host_hit) skip_q <= host_wdata_i;
  end
  assign skip_o = skip_q;

  // Mode selector: reserved and out-of-range codes are dropped
  logic [MW-1:0] mode_q;
  logic mode_dsp_hit, mode_host_hit, dsp_code_ok, host_code_ok;
  assign mode_dsp_hit  = dsp_we_i && (dsp_addr_i == AW'(ADDR_MODE));
  assign mode_host_hit = host_we_i && (host_addr_i == AW'(ADDR_MODE)) && run_cfg_i;
  assign dsp_code_ok   = (dsp_wdata_i <= DW'(MODE_SINE)) && mode_valid(8'(dsp_wdata_i));
  assign host_code_ok  = (host_wdata_i <= DW'(MODE_SINE)) && mode_valid(8'(host_wdata_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= '0;
    else if (sw_rst_i) mode_q <= '0;
    else if (mode_dsp_hit) begin
      if (dsp_code_ok) mode_q <= MW'(dsp_wdata_i);
    end else if (mode_host_hit && host_code_ok) begin
      mode_q <= MW'(host_wdata_i);
    end
  end
  assign mode_o = mode_q;

  // R6
  mode_code_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_valid(8'(mode_q)));

  // R5
  host_mode_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_addr_i == AW'(ADDR_MODE) && !run_cfg_i && !mode_dsp_hit && !sw_rst_i)
      |=> $stable(mode_q));

  // R10
  dsp_wins_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsp_we_i && host_we_i && dsp_addr_i == AW'(ADDR_MUTE) && host_addr_i == AW'(ADDR_MUTE)
     && !sw_rst_i) |=> (flags_o[FLAG_MUTE] == $past(dsp_wdata_i[0])));

  // R7
  sw_rst_clears_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> (mode_q == '0 && skip_q == '0 && flags_o == '0));

endmodule

// File: rtl/dcr_rd_mux.sv
module dcr_rd_mux
  import dcr_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned MW = 4
) (
  input  logic [AW-1:0]        addr_i,
  input  run_state_e           run_i,
  input  logic [MW-1:0]        mode_i,
  input  logic [DW-1:0]        skip_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic [DW-1:0]        rdata_o
);

  always_comb begin
    rdata_o = '0;
    if      (addr_i == AW'(ADDR_MODE))  rdata_o = DW'(mode_i);
    else if (addr_i == AW'(ADDR_CRC))   rdata_o = DW'(flags_i[FLAG_CRC]);
    else if (addr_i == AW'(ADDR_MUTE))  rdata_o = DW'(flags_i[FLAG_MUTE]);
    else if (addr_i == AW'(ADDR_RUN))   rdata_o = DW'(run_i);
    else if (addr_i == AW'(ADDR_SKIP))  rdata_o = skip_i;
    else if (addr_i == AW'(ADDR_PAUSE)) rdata_o = DW'(flags_i[FLAG_PAUSE]);
  end

endmodule

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
  import dcr_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned MW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_rst_i,
  input  logic          dsp_we_i,
  input  logic [AW-1:0] dsp_addr_i,
  input  logic [DW-1:0] dsp_wdata_i,
  output logic [DW-1:0] dsp_rdata_o,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          decode_en_o,
  output logic [MW-1:0] mode_o,
  output logic [DW-1:0] skip_o,
  output logic          crc_ignore_o,
  output logic          mute_o,
  output logic          pause_o,
  output logic          sine_test_o
);

  localparam int unsigned NUM_RD = 2;

  run_state_e           run;
  logic [NUM_FLAGS-1:0] flags;
  logic [AW-1:0]        rd_addr [NUM_RD];
  logic [DW-1:0]        rd_data [NUM_RD];

  dcr_run_fsm #(.AW(AW), .DW(DW)) u_run (
    .clk_i, .rst_ni, .sw_rst_i,
    .dsp_we_i, .dsp_addr_i, .dsp_wdata_i,
    .host_we_i, .host_addr_i, .host_wdata_i,
    .run_o (run)
  );

  dcr_cfg_regs #(.AW(AW), .DW(DW), .MW(MW)) u_cfg (
    .clk_i, .rst_ni, .sw_rst_i,
    .run_cfg_i (run == RUN_CFG),
    .dsp_we_i, .dsp_addr_i, .dsp_wdata_i,
    .host_we_i, .host_addr_i, .host_wdata_i,
    .mode_o, .skip_o,
    .flags_o (flags)
  );

  assign rd_addr[0] = dsp_addr_i;
  assign rd_addr[1] = host_addr_i;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    dcr_rd_mux #(.AW(AW), .DW(DW), .MW(MW)) u_mux (
      .addr_i  (rd_addr[p]),
      .run_i   (run),
      .mode_i  (mode_o),
      .skip_i  (skip_o),
      .flags_i (flags),
      .rdata_o (rd_data[p])
    );
  end

  assign dsp_rdata_o  = rd_data[0];
  assign host_rdata_o = rd_data[1];

  assign crc_ignore_o = flags[FLAG_CRC];
  assign mute_o       = flags[FLAG_MUTE];
  assign pause_o      = flags[FLAG_PAUSE];
  assign decode_en_o  = (run == RUN_GO);
  assign sine_test_o  = (mode_o == MW'(MODE_SINE));

  // R4
  decode_drops_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> !decode_en_o);

  // R3
  decode_rise_from_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decode_en_o ##1 decode_en_o |-> $past(run == RUN_CFG));

endmodule

// File: tb/dcr_ctrl_bench.sv
module dcr_ctrl_bench;

  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned MW = 4;

  // {kind[2], addr[8], data[8], rd_addr[8], exp_rd[8], exp_en[1], req[4]}
  // kind: 0 none, 1 dsp write, 2 host write, 3 software reset
  localparam int NV = 19;
  localparam logic [38:0] VEC [NV] = '{
    {2'd2, 8'h51, 8'd3,  8'h51, 8'd0,  1'b0, 4'd5},   // R5 locked before boot
    {2'd2, 8'h56, 8'd1,  8'h56, 8'd0,  1'b0, 4'd3},   // R3 start ignored in idle
    {2'd1, 8'h56, 8'd1,  8'h56, 8'd0,  1'b0, 4'd2},   // R2 wrong dsp value
    {2'd1, 8'h56, 8'd2,  8'h56, 8'd2,  1'b0, 4'd2},   // R2 boot done
    {2'd2, 8'h51, 8'd3,  8'h51, 8'd3,  1'b0, 4'd5},   // R5 window open
    {2'd2, 8'h51, 8'd5,  8'h51, 8'd3,  1'b0, 4'd6},   // R6 reserved
    {2'd2, 8'h51, 8'd2,  8'h51, 8'd3,  1'b0, 4'd6},   // R6 reserved
    {2'd2, 8'h51, 8'd11, 8'h51, 8'd3,  1'b0, 4'd6},   // R6 out of range
    {2'd2, 8'h52, 8'd1,  8'h52, 8'd1,  1'b0, 4'd5},   // R5 crc bypass
    {2'd2, 8'h57, 8'd8,  8'h57, 8'd8,  1'b0, 4'd5},   // R5 skip
    {2'd0, 8'h00, 8'd0,  8'h40, 8'd0,  1'b0, 4'd8},   // R8 unmapped
    {2'd2, 8'h56, 8'd1,  8'h56, 8'd1,  1'b1, 4'd3},   // R3 start
    {2'd2, 8'h51, 8'd4,  8'h51, 8'd3,  1'b1, 4'd5},   // R5 locked while running
    {2'd2, 8'h53, 8'd1,  8'h53, 8'd1,  1'b1, 4'd9},   // R9 mute while running
    {2'd2, 8'h58, 8'd1,  8'h58, 8'd1,  1'b1, 4'd9},   // R9 pause while running
    {2'd1, 8'h51, 8'd10, 8'h51, 8'd10, 1'b1, 4'd9},   // R9 dsp any state
    {2'd2, 8'h57, 8'd2,  8'h57, 8'd8,  1'b1, 4'd5},   // R5 skip locked
    {2'd3, 8'h00, 8'd0,  8'h56, 8'd0,  1'b0, 4'd4},   // R4 reset drops decode
    {2'd0, 8'h00, 8'd0,  8'h51, 8'd0,  1'b0, 4'd1}    // R1 mode cleared
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sw_rst_i = 1'b0;
  logic          dsp_we_i = 1'b0;
  logic [AW-1:0] dsp_addr_i = '0;
  logic [DW-1:0] dsp_wdata_i = '0;
  logic [DW-1:0] dsp_rdata_o;
  logic          host_we_i = 1'b0;
  logic [AW-1:0] host_addr_i = '0;
  logic [DW-1:0] host_wdata_i = '0;
  logic [DW-1:0] host_rdata_o;
  logic          decode_en_o;
  logic [MW-1:0] mode_o;
  logic [DW-1:0] skip_o;
  logic          crc_ignore_o, mute_o, pause_o, sine_test_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dcr_ctrl #(.AW(AW), .DW(DW), .MW(MW)) u_dcr_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    dsp_we_i = 1'b0; host_we_i = 1'b0; sw_rst_i = 1'b0;
  endtask

  // One write cycle, then park and point host read at rd
  task automatic step(input logic [1:0] kind, input logic [7:0] a, input logic [7:0] d,
                      input logic [7:0] rd);
    @(negedge clk_i);
    drive_idle();
    case (kind)
      2'd1: begin dsp_we_i = 1'b1; dsp_addr_i = a; dsp_wdata_i = d; end
      2'd2: begin host_we_i = 1'b1; host_addr_i = a; host_wdata_i = d; end
      2'd3: sw_rst_i = 1'b1;
      default: ;
    endcase
    @(negedge clk_i);
    drive_idle();
    host_addr_i = rd;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state at the ports
    host_addr_i = 8'h56; dsp_addr_i = 8'h57; #1;
    check("R1", host_rdata_o, 0);
    check("R1", dsp_rdata_o, 0);
    check("R1", {decode_en_o, sine_test_o, crc_ignore_o, mute_o, pause_o}, 0);
    check("R1", {mode_o, skip_o}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      step(v[38:37], v[36:29], v[28:21], v[20:13]);
      check($sformatf("R%0d", v[3:0]), host_rdata_o, v[12:5]);
      check($sformatf("R%0d", v[3:0]), decode_en_o, v[4]);
    end

    // R6 sine test code
    step(2'd1, 8'h51, 8'd10, 8'h51);
    check("R6", sine_test_o, 1);
    dsp_addr_i = 8'h51; #1;
    check("R8", dsp_rdata_o, 10);

    // R10 both ports write mute in one cycle
    @(negedge clk_i);
    dsp_we_i = 1'b1; dsp_addr_i = 8'h53; dsp_wdata_i = 8'd0;
    host_we_i = 1'b1; host_addr_i = 8'h53; host_wdata_i = 8'd1;
    @(negedge clk_i); drive_idle(); #1;
    check("R10", mute_o, 0);

    // R7 software reset beats a write in the same cycle
    step(2'd1, 8'h56, 8'd2, 8'h56);
    check("R2", host_rdata_o, 2);
    @(negedge clk_i);
    sw_rst_i = 1'b1; host_we_i = 1'b1; host_addr_i = 8'h56; host_wdata_i = 8'd1;
    dsp_we_i = 1'b1; dsp_addr_i = 8'h57; dsp_wdata_i = 8'd7;
    @(negedge clk_i); drive_idle(); host_addr_i = 8'h56; #1;
    check("R7", host_rdata_o, 0);
    check("R7", skip_o, 0);
    check("R7", decode_en_o, 0);
    check("R1", sine_test_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule